// File: doc/BRIEF.md
# Interrupt Priority Store with Security Views

This block holds one 8-bit priority value for every interrupt ID of an interrupt distributor. Software reaches it through a small access port that moves either one byte (a single ID) or one 32-bit word (four consecutive IDs). The full priority vector is also driven out flat, so that an arbiter elsewhere can rank pending interrupts. That ranking is not part of this block.

The block keeps two views of the same storage. A secure access, or any access while security is switched off, reads and writes the raw byte. A non-secure access while security is on is restricted in two ways. Entries whose group bit marks them as secure cannot be seen or changed. Entries it may touch are seen through a shifted view: on a write, the value is pushed into the upper half of the stored range, which is the lower-urgency half. On a read, the stored value is shifted back out.

The lowest IDs are internal to each processor and have no storage here. IDs at or above the implemented count do not exist. Accesses to either kind read as zero and change nothing. Read data comes back one cycle after the request. Any write that changes at least one entry raises a one-cycle update pulse.

Top module: `prio_bank`

## Requirements
- R1: Out of reset, every priority entry is zero, `rd_valid` is low and `upd_strobe` is low.
- R2: When `acc_secure` is high or `sec_off` is high, a byte write stores `acc_wdata[7:0]` unchanged and a byte read returns the stored byte unchanged in `rd_data[7:0]`, with `rd_data[31:8]` zero.
- R3: When `acc_secure` and `sec_off` are both low, a permitted write stores `{1'b1, v[7:1]}` for each written byte `v`.
- R4: When `acc_secure` and `sec_off` are both low, a permitted read returns `{p[6:0], 1'b0}` for each stored byte `p`.
- R5: When `acc_secure` and `sec_off` are both low, an entry whose bit in `grp_bits` is 0 reads as zero and is left unchanged by writes, even when other lanes of the same word are written.
- R6: A word access (`acc_word`=1) ignores `acc_addr[1:0]` and covers IDs base..base+3. ID base sits in bits 7:0 and ID base+3 sits in bits 31:24.
- R7: A word write changes nothing if its base ID is below `NUM_INT`, or if base+3 is at or above `NUM_IRQ`.
- R8: Each lane of a read, and each byte write, whose ID is below `NUM_INT` or at or above `NUM_IRQ` reads as zero and stores nothing.
- R9: A read request (`acc_en`=1, `acc_we`=0) gives `rd_valid` high for exactly the next cycle, with the data in `rd_data`. `rd_valid` is low after writes and after idle cycles.
- R10: `upd_strobe` is high for exactly the cycle after a write that stored at least one entry, and low otherwise.
- R11: `prio_flat[8*i +: 8]` shows the stored priority of ID i from the cycle after the write. It is always zero for IDs below `NUM_INT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 32-bit word of four IDs, 0 = single byte |
| acc_addr | input | ADDR_W | Byte offset, equal to the interrupt ID |
| acc_wdata | input | 32 | Write data |
| acc_secure | input | 1 | Access carries the secure attribute |
| sec_off | input | 1 | Security disabled: every access takes the raw view |
| grp_bits | input | NUM_IRQ | Per-ID group; 1 = non-secure group |
| rd_data | output | 32 | Read data, one cycle after request |
| rd_valid | output | 1 | Qualifies rd_data |
| prio_flat | output | 8*NUM_IRQ | Stored priorities, ID i at bits 8i+7:8i |
| upd_strobe | output | 1 | One-cycle pulse after a write that stored an entry |

## Verification
The hardest case to reach from the ports is a non-secure word write that straddles both groups. In that case some lanes must take the shifted value while their neighbours in the same word stay exactly as they were. The stimulus first uses secure writes to place distinct raw values in a block of IDs. It then sets the group bits so that only part of that block belongs to the non-secure group, and issues one restricted word write across the block. After that, secure raw reads and the flat vector expose each lane separately. The out-of-range word gates are approached from both sides: one base just below the internal boundary, one base whose last lane is the final implemented ID, and one base one word past that.

// File: rtl/prio_pkg.sv
package prio_pkg;

    localparam int PRIO_W = 8;
    localparam int LANES  = 4;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
        logic        strobe;
    } bank_out_t;

    // restricted-view store: force into the upper (less urgent) half
    function automatic prio_t ns_store_f(input prio_t v);
        return {1'b1, v[PRIO_W-1:1]};
    endfunction

    // restricted-view readback: shift stored value back out
    function automatic prio_t ns_show_f(input prio_t p);
        return {p[PRIO_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/prio_lane_map.sv
module prio_lane_map
    import prio_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_INT = 32,
    parameter int IDX_W   = $clog2(NUM_IRQ),
    parameter int ADDR_W  = IDX_W + 1
) (
    input  logic                         acc_word,
    input  logic [ADDR_W-1:0]            acc_addr,
    output logic [LANES-1:0][IDX_W-1:0]  lane_idx,
    output logic [LANES-1:0]             lane_live,
    output logic                         word_gate
);

    localparam logic [ADDR_W-1:0] INT_LIM = ADDR_W'(NUM_INT);
    localparam logic [ADDR_W-1:0] IRQ_LIM = ADDR_W'(NUM_IRQ);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] last;

    always_comb begin
        base = {acc_addr[ADDR_W-1:2], 2'b00};
        last = {acc_addr[ADDR_W-1:2], 2'b11};
        word_gate = !acc_word || ((base >= INT_LIM) && (last < IRQ_LIM));
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [ADDR_W-1:0] id;
        logic              used;
        always_comb begin
            if (acc_word) begin
                id   = base | ADDR_W'(k);
                used = 1'b1;
            end else begin
                id   = acc_addr;
                used = (k == 0);
            end
            lane_idx[k]  = id[IDX_W-1:0];
            lane_live[k] = used && (id >= INT_LIM) && (id < IRQ_LIM);
        end
    end

endmodule

// File: rtl/prio_view.sv
module prio_view
    import prio_pkg::*;
(
    input  logic  restrict_ns,
    input  logic  grp_ns,
    input  logic  live,
    input  prio_t cur,
    input  prio_t wbyte,
    output prio_t rd_byte,
    output logic  wr_perm,
    output prio_t wr_byte
);

    always_comb begin
        wr_perm = live && (!restrict_ns || grp_ns);
        wr_byte = restrict_ns ? ns_store_f(wbyte) : wbyte;
        if (!wr_perm) begin
            rd_byte = '0;
        end else if (restrict_ns) begin
            rd_byte = ns_show_f(cur);
        end else begin
            rd_byte = cur;
        end
    end

endmodule

// File: rtl/prio_store.sv
module prio_store
    import prio_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_INT = 32,
    parameter int IDX_W   = $clog2(NUM_IRQ)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             lane_we,
    input  logic [LANES-1:0][IDX_W-1:0]  lane_idx,
    input  logic [LANES-1:0][PRIO_W-1:0] lane_val,
    output logic [NUM_IRQ*PRIO_W-1:0]    prio_flat
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ent
        if (i < NUM_INT) begin : g_fixed
            assign prio_flat[i*PRIO_W +: PRIO_W] = '0;
        end else begin : g_reg
            prio_t ent_d;
            prio_t ent_q;

            always_comb begin
                ent_d = ent_q;
                for (int k = 0; k < LANES; k++) begin
                    if (lane_we[k] && (lane_idx[k] == IDX_W'(i))) begin
                        ent_d = lane_val[k];
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent_q <= '0;
                end else begin
                    ent_q <= ent_d;
                end
            end

            assign prio_flat[i*PRIO_W +: PRIO_W] = ent_q;
        end
    end

endmodule

// File: rtl/prio_bank.sv
module prio_bank
    import prio_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_INT = 32,
    parameter int IDX_W   = $clog2(NUM_IRQ),
    parameter int ADDR_W  = IDX_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_en,
    input  logic                      acc_we,
    input  logic                      acc_word,
    input  logic [ADDR_W-1:0]         acc_addr,
    input  logic [31:0]               acc_wdata,
    input  logic                      acc_secure,
    input  logic                      sec_off,
    input  logic [NUM_IRQ-1:0]        grp_bits,
    output logic [31:0]               rd_data,
    output logic                      rd_valid,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic                      upd_strobe
);

    logic [LANES-1:0][IDX_W-1:0]  lane_idx;
    logic [LANES-1:0]             lane_live;
    logic                         word_gate;
    logic [LANES-1:0]             lane_perm;
    logic [LANES-1:0]             lane_we;
    logic [LANES-1:0][PRIO_W-1:0] lane_rd;
    logic [LANES-1:0][PRIO_W-1:0] lane_wv;
    logic                         restrict_ns;
    prio_t                        ent_view [NUM_IRQ];

    bank_out_t out_d;
    bank_out_t out_q;

    assign restrict_ns = !acc_secure && !sec_off;

    prio_lane_map #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_INT (NUM_INT),
        .IDX_W   (IDX_W),
        .ADDR_W  (ADDR_W)
    ) u_map (
        .acc_word  (acc_word),
        .acc_addr  (acc_addr),
        .lane_idx  (lane_idx),
        .lane_live (lane_live),
        .word_gate (word_gate)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_unpack
        assign ent_view[i] = prio_flat[i*PRIO_W +: PRIO_W];
    end

    for (genvar k = 0; k < LANES; k++) begin : g_view
        prio_view u_view (
            .restrict_ns (restrict_ns),
            .grp_ns      (grp_bits[lane_idx[k]]),
            .live        (lane_live[k]),
            .cur         (ent_view[lane_idx[k]]),
            .wbyte       (acc_wdata[k*PRIO_W +: PRIO_W]),
            .rd_byte     (lane_rd[k]),
            .wr_perm     (lane_perm[k]),
            .wr_byte     (lane_wv[k])
        );
        assign lane_we[k] = acc_en && acc_we && word_gate && lane_perm[k];
    end

    prio_store #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_INT (NUM_INT),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_we   (lane_we),
        .lane_idx  (lane_idx),
        .lane_val  (lane_wv),
        .prio_flat (prio_flat)
    );

    always_comb begin
        out_d        = out_q;
        out_d.rvalid = acc_en && !acc_we;
        out_d.strobe = |lane_we;
        if (acc_en && !acc_we) begin
            out_d.rdata = acc_word ? lane_rd : {24'b0, lane_rd[0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data    = out_q.rdata;
    assign rd_valid   = out_q.rvalid;
    assign upd_strobe = out_q.strobe;

endmodule

// File: rtl/prio_bank_chk.sv
module prio_bank_chk
    import prio_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_INT = 32,
    parameter int IDX_W   = $clog2(NUM_IRQ),
    parameter int ADDR_W  = IDX_W + 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      acc_en,
    input logic                      acc_we,
    input logic                      acc_word,
    input logic [ADDR_W-1:0]         acc_addr,
    input logic                      acc_secure,
    input logic                      sec_off,
    input logic [NUM_IRQ-1:0]        grp_bits,
    input logic [31:0]               rd_data,
    input logic                      rd_valid,
    input logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    input logic                      upd_strobe
);

    localparam logic [ADDR_W-1:0] INT_LIM = ADDR_W'(NUM_INT);
    localparam logic [ADDR_W-1:0] IRQ_LIM = ADDR_W'(NUM_IRQ);

    logic ns_wr;
    assign ns_wr = acc_en && acc_we && !acc_secure && !sec_off;

    // R9: read data follows a read request, and only a read request
    p_rd_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we) |=> rd_valid);
    p_rd_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_en && !acc_we));

    // R10: pulse only after a write
    p_strobe_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |-> $past(acc_en && acc_we));

    // R7: gated word write leaves storage untouched
    p_word_low_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we && acc_word && (acc_addr < INT_LIM))
        |=> ($stable(prio_flat) && !upd_strobe));

    // R5: secure-group entry hidden from a restricted byte read
    p_grp0_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && !acc_word && !acc_secure && !sec_off &&
         (acc_addr < IRQ_LIM) && !grp_bits[acc_addr[IDX_W-1:0]])
        |=> (rd_data == 32'd0));

    // R3: any entry changed by a restricted write lands in the upper half
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_msb
        p_ns_upper_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ns_wr) && !$stable(prio_flat[i*PRIO_W +: PRIO_W]))
            |-> prio_flat[i*PRIO_W + PRIO_W - 1]);
    end

endmodule

bind prio_bank prio_bank_chk #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_INT (NUM_INT),
    .IDX_W   (IDX_W),
    .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/sim_prio_bank.sv
`timescale 1ns/1ps
module sim_prio_bank;

    localparam int NUM_IRQ = 64;
    localparam int NUM_INT = 32;
    localparam int IDX_W   = $clog2(NUM_IRQ);
    localparam int ADDR_W  = IDX_W + 1;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  acc_en, acc_we, acc_word, acc_secure, sec_off;
    logic [ADDR_W-1:0]     acc_addr;
    logic [31:0]           acc_wdata;
    logic [NUM_IRQ-1:0]    grp_bits;
    logic [31:0]           rd_data;
    logic                  rd_valid, upd_strobe;
    logic [NUM_IRQ*8-1:0]  prio_flat;

    int checks = 0;
    int errors = 0;
    logic [7:0]  model [NUM_IRQ];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    prio_bank #(.NUM_IRQ(NUM_IRQ), .NUM_INT(NUM_INT)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_word(acc_word), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_secure(acc_secure), .sec_off(sec_off), .grp_bits(grp_bits),
        .rd_data(rd_data), .rd_valid(rd_valid), .prio_flat(prio_flat),
        .upd_strobe(upd_strobe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit id_ok(input int id);
        return (id >= NUM_INT) && (id < NUM_IRQ);
    endfunction

    // monitor: pop expected read data as the design returns it
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected rd_valid", rd_data, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data === e, t, rd_data, e);
            end
        end
    end

    task automatic check_vec(input string req);
        bit ok = 1'b1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (prio_flat[i*8 +: 8] !== model[i]) ok = 1'b0;
        end
        check(ok, req, 32'(prio_flat[NUM_INT*8 +: 32]), {model[NUM_INT+3], model[NUM_INT+2], model[NUM_INT+1], model[NUM_INT]});
    endtask

    // driver: called at a negedge, returns at the following negedge
    task automatic access(input bit we, input bit word, input int addr,
                          input logic [31:0] d, input bit sec, input string req);
        bit restr;
        int base;
        int n;
        bit any;
        logic [31:0] rv;
        restr = !sec && !sec_off;
        base  = word ? (addr & ~3) : addr;
        n     = word ? 4 : 1;
        any   = 1'b0;
        rv    = 32'h0;
        acc_en = 1'b1; acc_we = we; acc_word = word;
        acc_addr = ADDR_W'(addr); acc_wdata = d; acc_secure = sec;
        for (int k = 0; k < n; k++) begin
            int id;
            logic [7:0] b;
            id = base + k;
            b  = d[8*k +: 8];
            if (id_ok(id) && (!restr || grp_bits[id])) begin
                if (!we) begin
                    rv[8*k +: 8] = restr ? {model[id][6:0], 1'b0} : model[id];
                end
            end
        end
        if (we) begin
            bit gate;
            gate = !word || (base >= NUM_INT && base + 3 < NUM_IRQ);
            for (int k = 0; k < n; k++) begin
                int id;
                id = base + k;
                if (gate && id_ok(id) && (!restr || grp_bits[id])) begin
                    model[id] = restr ? {1'b1, d[8*k+1 +: 7]} : d[8*k +: 8];
                    any = 1'b1;
                end
            end
        end else begin
            exp_q.push_back(rv);
            tag_q.push_back(req);
        end
        @(negedge clk);
        acc_en = 1'b0;
        check(upd_strobe === any, {req, " R10 strobe"}, 32'(upd_strobe), 32'(any));
        if (we) check(rd_valid === 1'b0, "R9 no rd_valid after write", 32'(rd_valid), 32'h0);
        check_vec({req, " R11 vector"});
    endtask

    initial begin
        #100000;
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM_IRQ; i++) model[i] = 8'h00;
        rst_n = 1'b0; acc_en = 1'b0; acc_we = 1'b0; acc_word = 1'b0;
        acc_addr = '0; acc_wdata = '0; acc_secure = 1'b0; sec_off = 1'b0;
        grp_bits = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(prio_flat === '0, "R1 vector zero", 32'(prio_flat[NUM_INT*8 +: 32]), 32'h0);
        check(rd_valid === 1'b0 && upd_strobe === 1'b0, "R1 flags low", {30'b0, rd_valid, upd_strobe}, 32'h0);
        access(0, 1, 32, 32'h0, 1, "R1 word read after reset");

        // R2 raw view: secure, and security disabled
        access(1, 0, 40, 32'hFFFF_FF5A, 1, "R2 secure byte write");
        access(0, 0, 40, 32'h0, 1, "R2 secure byte read");
        sec_off = 1'b1;
        access(1, 0, 41, 32'h0000_0033, 0, "R2 nonsecure write with security off");
        access(0, 0, 41, 32'h0, 0, "R2 nonsecure read with security off");
        sec_off = 1'b0;

        // R3/R4 restricted view on non-secure-group IDs 40..47
        grp_bits[47:40] = 8'hFF;
        access(1, 0, 42, 32'h0000_0064, 0, "R3 restricted byte write");
        access(0, 0, 42, 32'h0, 1, "R3 raw readback of restricted write");
        access(0, 0, 42, 32'h0, 0, "R4 restricted read of ID 42");
        access(0, 0, 40, 32'h0, 0, "R4 restricted read of ID 40");

        // R5 secure-group entry hidden
        access(1, 0, 50, 32'h0000_0077, 1, "R5 secure seed ID 50");
        access(1, 0, 50, 32'h0000_0011, 0, "R5 restricted write to group0 ignored");
        access(0, 0, 50, 32'h0, 0, "R5 restricted read of group0 zero");
        access(0, 0, 50, 32'h0, 1, "R5 secure read keeps value");

        // R6 word lane order, low address bits ignored
        access(1, 1, 46, 32'h4433_2211, 1, "R6 word write base 44");
        access(0, 1, 44, 32'h0, 1, "R6 word read base 44");
        access(0, 0, 45, 32'h0, 1, "R6 byte read of lane 1");
        access(0, 1, 44, 32'h0, 0, "R4 restricted word read");

        // R5 straddling word: 48..51 with only 48,49 non-secure
        access(1, 1, 48, 32'hA1B2_C3D4, 1, "R6 seed word 48");
        grp_bits[49:48] = 2'b11;
        access(1, 1, 48, 32'h1020_3040, 0, "R5 mixed-group word write");
        access(0, 1, 48, 32'h0, 1, "R5 mixed-group raw readback");

        // R7 word gates
        access(1, 1, 28, 32'hDEAD_BEEF, 1, "R7 word base internal ignored");
        access(1, 1, 60, 32'h0403_0201, 1, "R7 word at top edge accepted");
        access(0, 1, 60, 32'h0, 1, "R7 read top word");
        access(1, 1, 64, 32'hCAFE_F00D, 1, "R7 word past end ignored");
        access(0, 1, 28, 32'h0, 1, "R8 word read of internal IDs");

        // R8 byte out of range
        access(1, 0, 5, 32'h0000_00EE, 1, "R8 internal byte write ignored");
        access(0, 0, 5, 32'h0, 1, "R8 internal byte read zero");
        access(1, 0, 100, 32'h0000_00EE, 1, "R8 unimplemented byte write ignored");
        access(0, 0, 100, 32'h0, 1, "R8 unimplemented byte read zero");

        // R9 single-cycle valid
        @(negedge clk);
        check(rd_valid === 1'b0, "R9 rd_valid low when idle", 32'(rd_valid), 32'h0);
        check(exp_q.size() == 0, "R9 every read answered", exp_q.size(), 32'h0);
        check(upd_strobe === 1'b0, "R10 strobe low when idle", 32'(upd_strobe), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule